// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Preemption Grouping

This block watches a set of interrupt sources, each with a pending line and an enable line. It picks the most urgent source that is both pending and enabled, and reports its index. A second output says whether that winner is urgent enough to interrupt whatever is being serviced now. Each source has an 8-bit priority slot, but only the top four bits of the slot are stored, so there are sixteen levels. A lower stored value means a more urgent source.

A programmable split value divides the four stored bits into two parts. The upper part is the preemption group and the lower part is the subpriority. The winner among pending sources is chosen on the full stored value, with the lower index winning a full tie. So the subpriority only orders sources that share a group. Preemption looks only at the group part. A subpriority difference alone never interrupts an active handler.

Software programs the slots and the split value through a simple word-wide write port and can read them back. A global mask input holds back every source.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Source s has its priority slot in byte lane s%4 (bits 8*(s%4)+7 down to 8*(s%4)) of register word s/4. Only the upper four bits of each slot are stored. Reading a word returns the stored nibbles with the lower four bits of every lane equal to zero, whatever was written there.
- R2: The split value sits in bits [2:0] of word address NUM_WORDS (2 with 8 sources) and reads back in the same bits. A split value k means that the low k stored bits form the subpriority. Values above 4 behave as 4.
- R3: A source is eligible when its pending and enable bits are both 1. With no eligible source, win_valid is 0 and preempt_req is 0.
- R4: Among eligible sources, the winner is the one with the numerically lowest stored priority.
- R5: When two eligible sources have equal stored priority, the lower index wins.
- R6: While mask_all is 1, win_valid and preempt_req are 0. While mask_all is 0, it has no effect.
- R7: preempt_req is 1 when a winner exists and either no interrupt is active, or the winner's group (stored value shifted right by the effective split) is strictly lower than the active priority's group.
- R8: A winner whose group equals the active group does not raise preempt_req, even when its subpriority is lower.
- R9: The outputs are registered. A change on the inputs shows on the outputs after the next rising clock edge. After reset all outputs are 0, all stored priorities are 0 and the split is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Register word address for writes |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | AW | Register word address for reads |
| rd_data_o | output | 32 | Combinational read data |
| pend_i | input | N_SRC | Per-source pending bits |
| en_i | input | N_SRC | Per-source enable bits |
| mask_all_i | input | 1 | Global mask; 1 holds back every source |
| act_valid_i | input | 1 | An interrupt is currently being serviced |
| act_prio_i | input | PRIO_BITS | Stored priority value of the active interrupt |
| win_idx_o | output | IDXW | Index of the winning source |
| win_valid_o | output | 1 | A winner exists |
| preempt_o | output | 1 | The winner may preempt the active interrupt |

## Verification
The main function is tried with a fixed set of stored priorities and a series of pending and enable patterns. With a single source pending, only the eligibility logic is exercised. Two sources with the same value show the index tie-break. All sources pending shows that the lowest value is chosen. Removing the enable of the leading source shows that the enable gate comes before selection. The active priority is then set equal to, just above and below the winner's value, which separates strict from non-strict preemption. Changing the split between 0, 2 and an out-of-range value shows that the same pair of values can preempt under one split and not under another, while the winner itself stays the same.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int SLOT_W    = 8;
   localparam int WORD_W    = 32;
   localparam int LANES     = WORD_W / SLOT_W;
   localparam int SPLIT_W   = 3;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
   import irq_arb_pkg::*;
#(
   parameter int N_SRC     = 8,
   parameter int PRIO_BITS = 4,
   parameter int NUM_WORDS = (N_SRC + LANES - 1) / LANES,
   parameter int AW        = $clog2(NUM_WORDS + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en_i,
   input  logic [AW-1:0]              wr_addr_i,
   input  logic [WORD_W-1:0]          wr_data_i,
   input  logic [AW-1:0]              rd_addr_i,
   output logic [WORD_W-1:0]          rd_data_o,
   output logic [N_SRC*PRIO_BITS-1:0] prio_flat_o,
   output logic [SPLIT_W-1:0]         split_o
);
   localparam int SPLIT_ADDR = NUM_WORDS;

   if (PRIO_BITS < 1 || PRIO_BITS > SLOT_W) begin : g_bad_bits
      $error("PRIO_BITS must lie in 1..8");
   end
   if (N_SRC < 1) begin : g_bad_src
      $error("N_SRC must be at least 1");
   end

   logic [PRIO_BITS-1:0] prio_q [N_SRC];
   logic [SPLIT_W-1:0]   split_q;
   logic                 unused_wr_bits;

   assign unused_wr_bits = ^wr_data_i;

   for (genvar s = 0; s < N_SRC; s++) begin : g_slot
      localparam int WORD = s / LANES;
      localparam int TOP  = (s % LANES) * SLOT_W + SLOT_W - 1;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            prio_q[s] <= '0;
         end else if (wr_en_i && wr_addr_i == AW'(WORD)) begin
            prio_q[s] <= wr_data_i[TOP -: PRIO_BITS];
         end
      end
      assign prio_flat_o[s*PRIO_BITS +: PRIO_BITS] = prio_q[s];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         split_q <= '0;
      end else if (wr_en_i && wr_addr_i == AW'(SPLIT_ADDR)) begin
         split_q <= wr_data_i[SPLIT_W-1:0];
      end
   end
   assign split_o = split_q;

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == AW'(SPLIT_ADDR)) begin
         rd_data_o[SPLIT_W-1:0] = split_q;
      end else begin
         for (int s = 0; s < N_SRC; s++) begin
            if (rd_addr_i == AW'(s / LANES)) begin
               rd_data_o[(s % LANES) * SLOT_W + SLOT_W - 1 -: PRIO_BITS] = prio_q[s];
            end
         end
      end
   end
endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
   parameter int N_SRC     = 8,
   parameter int PRIO_BITS = 4,
   parameter int IDXW      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic [N_SRC-1:0]           elig_i,
   input  logic [N_SRC*PRIO_BITS-1:0] prio_flat_i,
   output logic [N_SRC-1:0]           grant_o,
   output logic [IDXW-1:0]            idx_o,
   output logic                       valid_o,
   output logic [PRIO_BITS-1:0]       prio_o
);
   always_comb begin
      grant_o = '0;
      idx_o   = '0;
      valid_o = 1'b0;
      prio_o  = '1;
      for (int s = 0; s < N_SRC; s++) begin
         // strict less-than keeps the lower index on a full tie (R5)
         if (elig_i[s] && (!valid_o || prio_flat_i[s*PRIO_BITS +: PRIO_BITS] < prio_o)) begin
            valid_o = 1'b1;
            idx_o   = IDXW'(s);
            prio_o  = prio_flat_i[s*PRIO_BITS +: PRIO_BITS];
            grant_o = '0;
            grant_o[s] = 1'b1;
         end
      end
   end

   always_comb begin
      assert_grant_onehot_R5 : assert ($onehot0(grant_o) && (valid_o == (|grant_o)));
   end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
   import irq_arb_pkg::*;
#(
   parameter int N_SRC     = 8,
   parameter int PRIO_BITS = 4,
   parameter int NUM_WORDS = (N_SRC + LANES - 1) / LANES,
   parameter int AW        = $clog2(NUM_WORDS + 1),
   parameter int IDXW      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en_i,
   input  logic [AW-1:0]        wr_addr_i,
   input  logic [31:0]          wr_data_i,
   input  logic [AW-1:0]        rd_addr_i,
   output logic [31:0]          rd_data_o,
   input  logic [N_SRC-1:0]     pend_i,
   input  logic [N_SRC-1:0]     en_i,
   input  logic                 mask_all_i,
   input  logic                 act_valid_i,
   input  logic [PRIO_BITS-1:0] act_prio_i,
   output logic [IDXW-1:0]      win_idx_o,
   output logic                 win_valid_o,
   output logic                 preempt_o
);
   logic [N_SRC*PRIO_BITS-1:0] prio_flat;
   logic [SPLIT_W-1:0]         split;
   logic [N_SRC-1:0]           elig, grant;
   logic [IDXW-1:0]            sel_idx;
   logic                       sel_valid;
   logic [PRIO_BITS-1:0]       sel_prio;
   logic [SPLIT_W-1:0]         sub_bits;
   logic [PRIO_BITS-1:0]       win_grp, act_grp;
   logic                       pre_d;

   irq_prio_regs #(.N_SRC(N_SRC), .PRIO_BITS(PRIO_BITS), .NUM_WORDS(NUM_WORDS), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
      .prio_flat_o(prio_flat), .split_o(split)
   );

   assign elig = mask_all_i ? '0 : (pend_i & en_i);

   irq_prio_select #(.N_SRC(N_SRC), .PRIO_BITS(PRIO_BITS), .IDXW(IDXW)) u_sel (
      .elig_i(elig), .prio_flat_i(prio_flat),
      .grant_o(grant), .idx_o(sel_idx), .valid_o(sel_valid), .prio_o(sel_prio)
   );

   // effective split saturates at the number of stored bits
   assign sub_bits = (32'(split) > PRIO_BITS) ? SPLIT_W'(PRIO_BITS) : split;
   assign win_grp  = sel_prio >> sub_bits;
   assign act_grp  = act_prio_i >> sub_bits;
   assign pre_d    = sel_valid && (!act_valid_i || win_grp < act_grp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_idx_o   <= '0;
         win_valid_o <= 1'b0;
         preempt_o   <= 1'b0;
      end else begin
         win_idx_o   <= sel_valid ? sel_idx : '0;
         win_valid_o <= sel_valid;
         preempt_o   <= pre_d;
      end
   end

   assert_mask_blocks_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      mask_all_i |=> (!win_valid_o && !preempt_o));
   assert_preempt_needs_win_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      preempt_o |-> win_valid_o);
   assert_win_was_elig_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      win_valid_o |-> ((($past(pend_i & en_i) >> win_idx_o) & N_SRC'(1)) != '0));
   assert_no_pre_without_elig_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_i & en_i) == '0) |=> (!win_valid_o && !preempt_o));
endmodule

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
   localparam int N = 8;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [N-1:0] pend = '0, en = '0;
   logic        mask_all = 1'b0, act_valid = 1'b0;
   logic [3:0]  act_prio = '0;
   logic [2:0]  win_idx;
   logic        win_valid, preempt;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   irq_prio_arbiter u_irq_prio_arbiter (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .pend_i(pend), .en_i(en),
      .mask_all_i(mask_all), .act_valid_i(act_valid), .act_prio_i(act_prio),
      .win_idx_o(win_idx), .win_valid_o(win_valid), .preempt_o(preempt)
   );

   // pend, en, mask, act_valid, act_prio, exp_valid, exp_idx, exp_pre
   // slots (split 0): s0=5 s1=3 s2=3 s3=7 s4=1 s5=9 s6=F s7=2
   localparam logic [26:0] VEC [0:7] = '{
      {8'h00, 8'hFF, 1'b0, 1'b0, 4'h0, 1'b0, 3'd0, 1'b0},  // R3 none pending
      {8'h01, 8'hFF, 1'b0, 1'b0, 4'h0, 1'b1, 3'd0, 1'b1},  // R7 idle core
      {8'h06, 8'hFF, 1'b0, 1'b0, 4'h0, 1'b1, 3'd1, 1'b1},  // R5 tie
      {8'hFF, 8'hFF, 1'b0, 1'b1, 4'h1, 1'b1, 3'd4, 1'b0},  // R4, R7 equal not strict
      {8'hFF, 8'hEF, 1'b0, 1'b1, 4'h3, 1'b1, 3'd7, 1'b1},  // R3 enable gate, R7
      {8'hFF, 8'hFF, 1'b1, 1'b0, 4'h0, 1'b0, 3'd0, 1'b0},  // R6 mask
      {8'h28, 8'hFF, 1'b0, 1'b1, 4'h8, 1'b1, 3'd3, 1'b1},  // R4, R6 mask clear
      {8'h40, 8'hBF, 1'b0, 1'b0, 4'h0, 1'b0, 3'd0, 1'b0}   // R3 pending not enabled
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic reg_read(input string req, input logic [1:0] a, input logic [31:0] exp);
      @(negedge clk);
      rd_addr = a;
      #1 check(req, rd_data, exp);
   endtask

   task automatic apply(input logic [N-1:0] p, input logic [N-1:0] e, input logic m,
                        input logic av, input logic [3:0] ap);
      @(negedge clk);
      pend = p; en = e; mask_all = m; act_valid = av; act_prio = ap;
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R9 reset valid", 32'(win_valid), 0);
      check("R9 reset idx", 32'(win_idx), 0);
      check("R9 reset preempt", 32'(preempt), 0);
      rst_n = 1'b1;
      reg_read("R9 reset slots", 2'd0, 32'h0);
      reg_read("R9 reset split", 2'd2, 32'h0);

      reg_write(2'd0, 32'h7F3A3559);
      reg_write(2'd1, 32'h2BF49C1E);
      reg_read("R1 word0 low nibbles", 2'd0, 32'h70303050);
      reg_read("R1 word1 low nibbles", 2'd1, 32'h20F09010);

      for (int i = 0; i < 8; i++) begin
         apply(VEC[i][26:19], VEC[i][18:11], VEC[i][10], VEC[i][9], VEC[i][8:5]);
         check($sformatf("R4 vec%0d valid", i), 32'(win_valid), 32'(VEC[i][4]));
         if (VEC[i][4]) check($sformatf("R5 vec%0d idx", i), 32'(win_idx), 32'(VEC[i][3:1]));
         check($sformatf("R7 vec%0d preempt", i), 32'(preempt), 32'(VEC[i][0]));
      end

      // R9 latency: output still old right after the driving edge's input change
      @(negedge clk);
      pend = 8'h10; en = 8'hFF; mask_all = 1'b0; act_valid = 1'b0;
      #1 check("R9 no early change", 32'(win_valid), 0);
      @(posedge clk); @(negedge clk);
      check("R9 after one edge", {31'd0, win_valid}, 1);
      check("R9 after one edge idx", 32'(win_idx), 4);

      // R2 / R8: split 2 -> source0 (5) group 1, active 4 group 1
      reg_write(2'd2, 32'hFFFFFFFA);
      reg_read("R2 split readback", 2'd2, 32'h2);
      apply(8'h01, 8'hFF, 1'b0, 1'b1, 4'h4);
      check("R8 same group no preempt", 32'(preempt), 0);
      check("R8 winner still valid", 32'(win_valid), 1);
      apply(8'h01, 8'hFF, 1'b0, 1'b1, 4'h8);
      check("R7 lower group preempts", 32'(preempt), 1);
      // R4 ordering unchanged by split: src4 (1) beats src7 (2) inside group 0
      apply(8'h90, 8'hFF, 1'b0, 1'b1, 4'h4);
      check("R4 subpriority orders within group", 32'(win_idx), 4);
      check("R7 group0 below group1", 32'(preempt), 1);

      // R2 out of range value behaves as 4: single group, no preemption
      reg_write(2'd2, 32'h7);
      reg_read("R2 split 7 readback", 2'd2, 32'h7);
      apply(8'h10, 8'hFF, 1'b0, 1'b1, 4'hF);
      check("R2 saturated split no preempt", 32'(preempt), 0);
      check("R2 saturated split winner", 32'(win_idx), 4);
      apply(8'h10, 8'hFF, 1'b0, 1'b0, 4'hF);
      check("R7 idle core preempts", 32'(preempt), 1);

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog actual=hang expected=finish");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule